// File: doc/BRIEF.md
# Tagged Set-Associative Branch Target Buffer

This block predicts, in the same cycle as the fetch, whether the instruction at the fetch address is a taken branch and where it goes. The table is set associative. Every entry holds the branch's full upper address bits as a tag, a 2-bit saturating direction counter and the stored destination address. The set is chosen by the low word-address bits of the fetch PC. A lookup hits only when a valid entry in that set carries a matching tag. Only then are the entry's direction bits used. When the lookup misses, or the hit predicts not taken, the next fetch address is the sequential one, PC + 4.

When a branch resolves, the back end presents its address, its outcome and its destination. If the branch already has an entry, the direction counter steps toward the outcome and the destination is rewritten. If it has no entry, one is allocated in its set. An empty way is used first. When the set is full, the way whose use count is smallest is replaced. Each way's use count rises by one on every lookup hit and saturates at its maximum. Ties go to the lowest way index.

Top module: `branch_target_buffer`

## Requirements
- R1: After a synchronous active-low reset, every entry is invalid, so every lookup misses, reports not taken and gives PC + 4 as the next address.
- R2: The set index is PC[5:2] and the tag is PC[31:6]. A lookup hits only if a valid entry in the indexed set has the same tag. The set has 4 ways.
- R3: Lookup results are combinational in the same cycle. On a hit whose counter is 2 or 3, the block reports taken and the next address is the stored destination. Otherwise it reports not taken and the next address is PC + 4.
- R4: The direction counter encodes 0 strongly not taken, 1 weakly not taken, 2 weakly taken and 3 strongly taken. A resolve that hits adds one for taken, saturating at 3. It subtracts one for not taken, saturating at 0.
- R5: Every resolve writes its destination address into the matching or newly allocated entry. The next lookup returns that address.
- R6: A resolve that misses allocates an entry. Its counter starts at 2 if the branch was taken and at 1 if not, and its use count starts at 0.
- R7: The allocation victim is the lowest-index invalid way. If all ways are valid, it is the way with the smallest use count, and ties go to the lowest index.
- R8: Each lookup hit adds one to the hitting way's use count. The count saturates at 7 (3 bits) and does not wrap.
- R9: Sets are independent. Allocation or update in one set leaves lookups in other sets unchanged.
- R10: At most one way of a set matches a given address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_pc | input | 32 | Fetch address being looked up |
| lk_hit | output | 1 | A valid tagged entry matches the fetch address |
| lk_taken | output | 1 | Predicted taken |
| lk_next_pc | output | 32 | Predicted next fetch address |
| rs_valid | input | 1 | A resolved branch is presented |
| rs_pc | input | 32 | Address of the resolved branch |
| rs_taken | input | 1 | Resolved outcome, 1 for taken |
| rs_target | input | 32 | Resolved destination address |

## Verification
The bench builds the block with its defaults: 16 sets, 4 ways, 32-bit addresses and a 3-bit use count. With 4 ways, a single set fills after four allocations, so both the empty-way rule and the least-use eviction, including a tie between equal counts, are exercised within a few dozen cycles. With a 3-bit count, ten extra hits on one way are enough to show saturation. A wrapped count would instead make that heavily used way the victim. An extra set (index 1) confirms that traffic in one set leaves the others untouched.

// File: rtl/btb_pkg.sv
// Shared types for the branch target buffer: the direction-counter
// encoding and its saturating step. Assumes a 2-bit counter.
package btb_pkg;

    typedef enum logic [1:0] {
        DIR_STRONG_NT = 2'd0,
        DIR_WEAK_NT   = 2'd1,
        DIR_WEAK_T    = 2'd2,
        DIR_STRONG_T  = 2'd3
    } dir_e;

    // Move the counter one step toward the resolved outcome, saturating.
    function automatic dir_e dir_step(input dir_e cur, input logic taken);
        dir_e nxt;
        nxt = cur;
        if (taken && cur != DIR_STRONG_T)
            nxt = dir_e'(cur + 2'd1);
        else if (!taken && cur != DIR_STRONG_NT)
            nxt = dir_e'(cur - 2'd1);
        return nxt;
    endfunction

    // Starting state of a freshly allocated entry.
    function automatic dir_e dir_init(input logic taken);
        return taken ? DIR_WEAK_T : DIR_WEAK_NT;
    endfunction

endpackage

// File: rtl/btb_way.sv
// One way of the branch target buffer: SETS entries of valid, tag,
// direction counter, destination and use count. Two combinational read
// ports (lookup index, resolve index) and one write port at the resolve
// index. Assumes the caller never raises upd_en and alloc_en together.
module btb_way
    import btb_pkg::*;
#(
    parameter int SETS   = 16,
    parameter int TAG_W  = 26,
    parameter int ADDR_W = 32,
    parameter int USE_W  = 3,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  lk_idx,
    input  logic [IDX_W-1:0]  rs_idx,
    input  logic              inc_use,
    input  logic              upd_en,
    input  logic              alloc_en,
    input  logic [TAG_W-1:0]  wr_tag,
    input  dir_e              wr_dir,
    input  logic [ADDR_W-1:0] wr_target,
    output logic              lk_vld_o,
    output logic [TAG_W-1:0]  lk_tag_o,
    output dir_e              lk_dir_o,
    output logic [ADDR_W-1:0] lk_target_o,
    output logic              rs_vld_o,
    output logic [TAG_W-1:0]  rs_tag_o,
    output dir_e              rs_dir_o,
    output logic [USE_W-1:0]  rs_use_o
);

    localparam logic [USE_W-1:0] USE_MAX = {USE_W{1'b1}};

    logic              vld_q    [SETS];
    logic [TAG_W-1:0]  tag_q    [SETS];
    dir_e              dir_q    [SETS];
    logic [ADDR_W-1:0] target_q [SETS];
    logic [USE_W-1:0]  use_q    [SETS];

    // Read ports: lookup side and resolve side.
    always_comb begin
        lk_vld_o    = vld_q[lk_idx];
        lk_tag_o    = tag_q[lk_idx];
        lk_dir_o    = dir_q[lk_idx];
        lk_target_o = target_q[lk_idx];
        rs_vld_o    = vld_q[rs_idx];
        rs_tag_o    = tag_q[rs_idx];
        rs_dir_o    = dir_q[rs_idx];
        rs_use_o    = use_q[rs_idx];
    end

    // Entry storage: clear on reset, count hits, update or allocate on resolve.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                vld_q[s]    <= 1'b0;
                tag_q[s]    <= '0;
                dir_q[s]    <= DIR_STRONG_NT;
                target_q[s] <= '0;
                use_q[s]    <= '0;
            end
        end else begin
            if (inc_use && use_q[lk_idx] != USE_MAX)
                use_q[lk_idx] <= use_q[lk_idx] + 1'b1;
            if (upd_en) begin
                dir_q[rs_idx]    <= wr_dir;
                target_q[rs_idx] <= wr_target;
            end
            if (alloc_en) begin
                vld_q[rs_idx]    <= 1'b1;
                tag_q[rs_idx]    <= wr_tag;
                dir_q[rs_idx]    <= wr_dir;
                target_q[rs_idx] <= wr_target;
                use_q[rs_idx]    <= '0;
            end
        end
    end

    AST_ALLOC_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |=> vld_q[$past(rs_idx)] && use_q[$past(rs_idx)] == '0); // R6

    AST_DIR_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |=> (dir_q[$past(rs_idx)] == $past(rs_dir_o)) ||
                   (dir_q[$past(rs_idx)] == dir_e'($past(rs_dir_o) + 2'd1)) ||
                   (dir_q[$past(rs_idx)] == dir_e'($past(rs_dir_o) - 2'd1))); // R4

    AST_USE_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_use && use_q[lk_idx] == USE_MAX && !(alloc_en && rs_idx == lk_idx))
        |=> use_q[$past(lk_idx)] == USE_MAX); // R8

endmodule

// File: rtl/btb_victim.sv
// Victim selection for one set: lowest-index invalid way first, otherwise
// the way with the least use count, ties to the lowest index.
// Assumes use counts of invalid ways are irrelevant.
module btb_victim #(
    parameter int WAYS  = 4,
    parameter int USE_W = 3,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [WAYS-1:0]             way_vld,
    input  logic [WAYS-1:0][USE_W-1:0]  way_use,
    output logic [WAYS-1:0]             victim_oh
);

    logic [WAY_W-1:0] pick;
    logic             found_free;
    logic [USE_W-1:0] best;

    // Priority scan for a free way, then a least-use scan.
    always_comb begin
        pick       = '0;
        found_free = 1'b0;
        best       = way_use[0];
        for (int w = 0; w < WAYS; w++) begin
            if (!found_free && !way_vld[w]) begin
                pick       = WAY_W'(w);
                found_free = 1'b1;
            end
        end
        if (!found_free) begin
            for (int w = 1; w < WAYS; w++) begin
                if (way_use[w] < best) begin
                    best = way_use[w];
                    pick = WAY_W'(w);
                end
            end
        end
        victim_oh       = '0;
        victim_oh[pick] = 1'b1;
    end

    AST_VICTIM_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(victim_oh) == 1); // R7

    AST_VICTIM_FREE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (way_vld != {WAYS{1'b1}}) |-> ((victim_oh & way_vld) == '0)); // R7

    for (genvar g = 0; g < WAYS; g++) begin : g_min_chk
        AST_VICTIM_LEAST: assert property (@(posedge clk) disable iff (!rst_n)
            (way_vld == {WAYS{1'b1}}) |-> way_use[pick] <= way_use[g]); // R7
    end

endmodule

// File: rtl/branch_target_buffer.sv
// Tagged set-associative branch target buffer. Lookups are combinational
// on the fetch PC. Resolves update or allocate at the clock edge.
// Assumes word-aligned instructions of INSTR_BYTES bytes.
module branch_target_buffer
    import btb_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int SETS        = 16,
    parameter int WAYS        = 4,
    parameter int USE_W       = 3,
    parameter int INSTR_BYTES = 4,
    localparam int OFS_W = $clog2(INSTR_BYTES),
    localparam int IDX_W = $clog2(SETS),
    localparam int TAG_W = ADDR_W - IDX_W - OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_pc,
    output logic              lk_hit,
    output logic              lk_taken,
    output logic [ADDR_W-1:0] lk_next_pc,
    input  logic              rs_valid,
    input  logic [ADDR_W-1:0] rs_pc,
    input  logic              rs_taken,
    input  logic [ADDR_W-1:0] rs_target
);

    logic [IDX_W-1:0] lk_idx, rs_idx;
    logic [TAG_W-1:0] lk_tag, rs_tag;

    logic [WAYS-1:0]             w_lk_vld, w_rs_vld, lk_match, rs_match;
    logic [WAYS-1:0]             inc_use, upd_en, alloc_en, victim_oh;
    logic [WAYS-1:0][USE_W-1:0]  w_rs_use;
    logic [TAG_W-1:0]            w_lk_tag [WAYS];
    logic [TAG_W-1:0]            w_rs_tag [WAYS];
    dir_e                        w_lk_dir [WAYS];
    dir_e                        w_rs_dir [WAYS];
    logic [ADDR_W-1:0]           w_lk_tgt [WAYS];

    logic              rs_hit;
    dir_e              lk_dir_sel, rs_dir_sel, wr_dir;
    logic [ADDR_W-1:0] lk_tgt_sel;

    // Split both addresses into set index and tag.
    always_comb begin
        lk_idx = lk_pc[OFS_W +: IDX_W];
        lk_tag = lk_pc[ADDR_W-1 -: TAG_W];
        rs_idx = rs_pc[OFS_W +: IDX_W];
        rs_tag = rs_pc[ADDR_W-1 -: TAG_W];
    end

    for (genvar g = 0; g < WAYS; g++) begin : g_way
        btb_way #(
            .SETS(SETS), .TAG_W(TAG_W), .ADDR_W(ADDR_W), .USE_W(USE_W)
        ) u_way (
            .clk        (clk),
            .rst_n      (rst_n),
            .lk_idx     (lk_idx),
            .rs_idx     (rs_idx),
            .inc_use    (inc_use[g]),
            .upd_en     (upd_en[g]),
            .alloc_en   (alloc_en[g]),
            .wr_tag     (rs_tag),
            .wr_dir     (wr_dir),
            .wr_target  (rs_target),
            .lk_vld_o   (w_lk_vld[g]),
            .lk_tag_o   (w_lk_tag[g]),
            .lk_dir_o   (w_lk_dir[g]),
            .lk_target_o(w_lk_tgt[g]),
            .rs_vld_o   (w_rs_vld[g]),
            .rs_tag_o   (w_rs_tag[g]),
            .rs_dir_o   (w_rs_dir[g]),
            .rs_use_o   (w_rs_use[g])
        );

        // Tag compare and per-way write enables.
        always_comb begin
            lk_match[g] = w_lk_vld[g] && (w_lk_tag[g] == lk_tag);
            rs_match[g] = w_rs_vld[g] && (w_rs_tag[g] == rs_tag);
            inc_use[g]  = lk_valid && lk_match[g];
            upd_en[g]   = rs_valid && rs_match[g];
            alloc_en[g] = rs_valid && !rs_hit && victim_oh[g];
        end
    end

    btb_victim #(.WAYS(WAYS), .USE_W(USE_W)) u_victim (
        .clk      (clk),
        .rst_n    (rst_n),
        .way_vld  (w_rs_vld),
        .way_use  (w_rs_use),
        .victim_oh(victim_oh)
    );

    // One-hot mux of the matching way on each port.
    always_comb begin
        lk_dir_sel = DIR_STRONG_NT;
        lk_tgt_sel = '0;
        rs_dir_sel = DIR_STRONG_NT;
        for (int w = 0; w < WAYS; w++) begin
            if (lk_match[w]) begin
                lk_dir_sel = w_lk_dir[w];
                lk_tgt_sel = w_lk_tgt[w];
            end
            if (rs_match[w])
                rs_dir_sel = w_rs_dir[w];
        end
        rs_hit = |rs_match;
    end

    // New counter value: a step on a hit, a weak start on allocation.
    always_comb begin
        wr_dir = rs_hit ? dir_step(rs_dir_sel, rs_taken) : dir_init(rs_taken);
    end

    // Prediction outputs.
    always_comb begin
        lk_hit     = lk_valid && (|lk_match);
        lk_taken   = lk_hit && lk_dir_sel[1];
        lk_next_pc = lk_taken ? lk_tgt_sel : lk_pc + ADDR_W'(INSTR_BYTES);
    end

    AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match) && $onehot0(rs_match)); // R10

    AST_TAKEN_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        lk_taken |-> lk_hit); // R3

    AST_MISS_SEQUENTIAL: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !lk_hit) |-> lk_next_pc == lk_pc + ADDR_W'(INSTR_BYTES)); // R3

    AST_ALLOC_ONLY_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_valid && rs_hit) |-> alloc_en == '0); // R10

endmodule

// File: tb/branch_target_buffer_tb.sv
module branch_target_buffer_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_pc = '0;
    logic        lk_hit, lk_taken;
    logic [31:0] lk_next_pc;
    logic        rs_valid = 1'b0;
    logic [31:0] rs_pc = '0;
    logic        rs_taken = 1'b0;
    logic [31:0] rs_target = '0;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;  // 50 MHz

    branch_target_buffer u_dut (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_pc(lk_pc),
        .lk_hit(lk_hit), .lk_taken(lk_taken), .lk_next_pc(lk_next_pc),
        .rs_valid(rs_valid), .rs_pc(rs_pc), .rs_taken(rs_taken), .rs_target(rs_target)
    );

    typedef struct packed {
        logic        is_rs;
        logic [31:0] pc;
        logic        tk;
        logic [31:0] tgt;
        logic        e_hit;
        logic        e_tk;
        logic [31:0] e_next;
    } vec_t;

    // Addresses 0x1000..0x6000 all map to set 0; 0x1004 maps to set 1.
    localparam int NV = 34;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 32'h1000, 1'b0, 32'h0,    1'b0, 1'b0, 32'h1004}, // R1 empty
        '{1'b1, 32'h1000, 1'b1, 32'h8000, 1'b0, 1'b0, 32'h0},
        '{1'b0, 32'h1000, 1'b0, 32'h0,    1'b1, 1'b1, 32'h8000}, // R6 weak taken
        '{1'b1, 32'h1000, 1'b0, 32'h8000, 1'b0, 1'b0, 32'h0},
        '{1'b0, 32'h1000, 1'b0, 32'h0,    1'b1, 1'b0, 32'h1004}, // R4 down to 1
        '{1'b1, 32'h1000, 1'b0, 32'h8000, 1'b0, 1'b0, 32'h0},
        '{1'b1, 32'h1000, 1'b0, 32'h8000, 1'b0, 1'b0, 32'h0},
        '{1'b0, 32'h1000, 1'b0, 32'h0,    1'b1, 1'b0, 32'h1004}, // R4 floor 0
        '{1'b1, 32'h1000, 1'b1, 32'h8000, 1'b0, 1'b0, 32'h0},
        '{1'b1, 32'h1000, 1'b1, 32'h8000, 1'b0, 1'b0, 32'h0},
        '{1'b0, 32'h1000, 1'b0, 32'h0,    1'b1, 1'b1, 32'h8000}, // R4 up to 2
        '{1'b1, 32'h1000, 1'b1, 32'h8000, 1'b0, 1'b0, 32'h0},
        '{1'b1, 32'h1000, 1'b1, 32'h8000, 1'b0, 1'b0, 32'h0},
        '{1'b1, 32'h1000, 1'b0, 32'h8000, 1'b0, 1'b0, 32'h0},
        '{1'b0, 32'h1000, 1'b0, 32'h0,    1'b1, 1'b1, 32'h8000}, // R4 ceiling 3
        '{1'b1, 32'h1000, 1'b1, 32'h9000, 1'b0, 1'b0, 32'h0},
        '{1'b0, 32'h1000, 1'b0, 32'h0,    1'b1, 1'b1, 32'h9000}, // R5 new target
        '{1'b1, 32'h2000, 1'b0, 32'hA000, 1'b0, 1'b0, 32'h0},
        '{1'b1, 32'h3000, 1'b1, 32'hB000, 1'b0, 1'b0, 32'h0},
        '{1'b1, 32'h4000, 1'b1, 32'hC000, 1'b0, 1'b0, 32'h0},
        '{1'b0, 32'h2000, 1'b0, 32'h0,    1'b1, 1'b0, 32'h2004}, // R6 weak not taken
        '{1'b0, 32'h3000, 1'b0, 32'h0,    1'b1, 1'b1, 32'hB000}, // R2 way 2
        '{1'b0, 32'h3000, 1'b0, 32'h0,    1'b1, 1'b1, 32'hB000}, // R2
        '{1'b0, 32'h4000, 1'b0, 32'h0,    1'b1, 1'b1, 32'hC000}, // R2 way 3
        '{1'b1, 32'h5000, 1'b1, 32'hD000, 1'b0, 1'b0, 32'h0},
        '{1'b0, 32'h2000, 1'b0, 32'h0,    1'b0, 1'b0, 32'h2004}, // R7 tie to lowest
        '{1'b0, 32'h5000, 1'b0, 32'h0,    1'b1, 1'b1, 32'hD000}, // R7
        '{1'b0, 32'h4000, 1'b0, 32'h0,    1'b1, 1'b1, 32'hC000}, // R7
        '{1'b1, 32'h2000, 1'b1, 32'hE000, 1'b0, 1'b0, 32'h0},
        '{1'b0, 32'h5000, 1'b0, 32'h0,    1'b0, 1'b0, 32'h5004}, // R7 least use
        '{1'b0, 32'h1000, 1'b0, 32'h0,    1'b1, 1'b1, 32'h9000}, // R7 busy way kept
        '{1'b0, 32'h1004, 1'b0, 32'h0,    1'b0, 1'b0, 32'h1008}, // R9 set 1 empty
        '{1'b1, 32'h1004, 1'b1, 32'hF000, 1'b0, 1'b0, 32'h0},
        '{1'b0, 32'h1004, 1'b0, 32'h0,    1'b1, 1'b1, 32'hF000}  // R9 set 1 own entry
    };

    task automatic do_lookup(input logic [31:0] pc, input logic e_hit,
                             input logic e_tk, input logic [31:0] e_next,
                             input string req);
        @(negedge clk);
        rs_valid = 1'b0;
        lk_valid = 1'b1;
        lk_pc    = pc;
        #2;
        n_chk++;
        if (lk_hit !== e_hit || lk_taken !== e_tk || lk_next_pc !== e_next) begin
            n_bad++;
            $display("FAIL %s pc=%h: hit/taken/next = %b/%b/%h, expected %b/%b/%h",
                     req, pc, lk_hit, lk_taken, lk_next_pc, e_hit, e_tk, e_next);
        end
    endtask

    task automatic do_resolve(input logic [31:0] pc, input logic tk,
                              input logic [31:0] tgt);
        @(negedge clk);
        lk_valid  = 1'b0;
        rs_valid  = 1'b1;
        rs_pc     = pc;
        rs_taken  = tk;
        rs_target = tgt;
        @(negedge clk);
        rs_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // Reset state check (R1).
        do_lookup(32'h1000, 1'b0, 1'b0, 32'h1004, "R1");
        for (int i = 0; i < NV; i++) begin
            if (VEC[i].is_rs)
                do_resolve(VEC[i].pc, VEC[i].tk, VEC[i].tgt);
            else
                do_lookup(VEC[i].pc, VEC[i].e_hit, VEC[i].e_tk, VEC[i].e_next, "R3");
        end
        // Use-count saturation: way 0 reaches 7 and stays there (R8).
        for (int i = 0; i < 10; i++)
            do_lookup(32'h1000, 1'b1, 1'b1, 32'h9000, "R8");
        for (int i = 0; i < 3; i++) begin
            do_lookup(32'h2000, 1'b1, 1'b1, 32'hE000, "R8");
            do_lookup(32'h3000, 1'b1, 1'b1, 32'hB000, "R8");
            do_lookup(32'h4000, 1'b1, 1'b1, 32'hC000, "R8");
        end
        // Counts 7,3,5,5: way 1 must go, not the saturated way 0.
        do_resolve(32'h6000, 1'b1, 32'h6100);
        do_lookup(32'h1000, 1'b1, 1'b1, 32'h9000, "R8");
        do_lookup(32'h2000, 1'b0, 1'b0, 32'h2004, "R7");
        do_lookup(32'h6000, 1'b1, 1'b1, 32'h6100, "R6");
        do_lookup(32'h1004, 1'b1, 1'b1, 32'hF000, "R9");
        // Reset clears every entry (R1).
        @(negedge clk);
        lk_valid = 1'b0;
        rst_n    = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        do_lookup(32'h1000, 1'b0, 1'b0, 32'h1004, "R1");
        do_lookup(32'h1004, 1'b0, 1'b0, 32'h1008, "R1");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule